// File: doc/BRIEF.md
# Channel Output Load and Clear Controller

This block decides when each channel's DAC register takes a new code from its two holding registers. A holding register is filled by an upstream arithmetic engine. A per-channel source bit picks which of the two holding registers feeds the DAC register. A load strobe (active low) commits the new codes. Only channels whose holding registers were written since the previous commit are updated, which keeps unchanged channels quiet.

The busy line is an active-low, open-drain net that several devices share. The block pulls it low while the local engine is computing and for a fixed number of cycles after the source bits are rewritten. It samples the resolved line level. A load that falls while the line is low is remembered and carried out as soon as the line is released. A load strobe held low commits on every release of the line.

An active-low clear input forces every output to the signal-ground code while it is low, without disturbing any stored value. Load requests made during clear are dropped.

Top module: `upd_ctrl`

## Requirements
- R1: After reset the DAC registers, holding registers and source bits are zero, `upd_o` is zero and `busy_pull_o` is low. With `clr_ni` high, every `out_o` lane reads 0.
- R2: A load request exists at a rising clock edge where `clr_ni` and `busy_ni` are high and `load_ni` is low after having been high at the previous edge. A load request commits at that same edge, so DAC registers and `upd_o` change right after it.
- R3: A commit copies a channel (and sets its bit in `upd_o` for one cycle) only if that channel's holding registers were written since its last copy. A commit with no such write leaves the channel and its `upd_o` bit unchanged.
- R4: Source bit 0 selects holding register A and 1 selects holding register B. All source bits are loaded together from `ab_sel_i` (bit c for channel c) when `ab_we_i` is high. A write with `hold_b_i`=1 targets register B and one with `hold_b_i`=0 targets register A.
- R5: A load falling edge seen while `busy_ni` is low, with `clr_ni` high, is held pending. It commits at the first edge at which `busy_ni` is high.
- R6: While `load_ni` stays low, every edge at which `busy_ni` is high after being low at the previous edge commits.
- R7: `busy_pull_o` is high whenever `calc_busy_i` is high. It is also high for exactly AB_HOLD cycles following an edge at which `ab_we_i` is high.
- R8: While `clr_ni` is low, every lane of `out_o` equals GND_CODE. Load falling edges are ignored, no bit of `upd_o` rises, and a pending load request is discarded.
- R9: When `clr_ni` returns high, `out_o` again shows the DAC registers unchanged. Holding writes made during clear are kept and take effect at the next commit.
- R10: If a holding write and a commit fall on the same edge, the DAC register takes the older holding value and the channel stays marked as written for the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Load strobe, active low |
| clr_ni | input | 1 | Clear to signal ground, active low |
| busy_ni | input | 1 | Resolved level of the shared busy net (0 = busy) |
| busy_pull_o | output | 1 | Open-drain enable: 1 pulls the shared busy net low |
| calc_busy_i | input | 1 | Local arithmetic engine is computing |
| ab_we_i | input | 1 | Load all source-select bits |
| ab_sel_i | input | N_CH | New source-select bits, one per channel |
| hold_we_i | input | 1 | Holding register write strobe |
| hold_b_i | input | 1 | Holding write target: 0 = A, 1 = B |
| hold_ch_i | input | CW | Holding write channel index |
| hold_data_i | input | DW | Holding write data |
| out_o | output | N_CH*DW | Per-channel output codes, channel c at bits c*DW +: DW |
| upd_o | output | N_CH | One-cycle pulse per channel copied by a commit |

## Verification
The bench builds the block with N_CH=4, DW=8, AB_HOLD=6 and GND_CODE=0x80. Four channels are enough for updates of mixed subsets and for a channel that is written but sourced from the other register. A six-cycle hold after a source write is short enough to watch the pull start and end. It is also long enough for a load to land inside that window. A ground code of 0x80 is distinct from the reset value 0, so a clear cannot be confused with an untouched channel. An external hold on the modelled busy net stands in for another device, so the latched-load and held-low cases can be reached without any local activity.

// File: rtl/upd_ctrl_pkg.sv
package upd_ctrl_pkg;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;
endpackage

// File: rtl/upd_trigger.sv
module upd_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_ni,
  input  logic clr_ni,
  input  logic busy_ni,
  output logic fire_o
);
  logic load_q, line_q, pend_q;
  logic load_fall, line_rise;

  assign load_fall = load_q & ~load_ni;
  assign line_rise = ~line_q & busy_ni;
  assign fire_o    = clr_ni & busy_ni & (pend_q | load_fall | (~load_ni & line_rise));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b1;
      line_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      load_q <= load_ni;
      line_q <= busy_ni;
      if (!clr_ni || fire_o) pend_q <= 1'b0;
      else if (load_fall)    pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/busy_hold.sv
module busy_hold #(
  parameter int AB_HOLD = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ab_we_i,
  input  logic calc_busy_i,
  output logic pull_o
);
  localparam int TW = $clog2(AB_HOLD + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (ab_we_i)        cnt_q <= TW'(AB_HOLD);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pull_o = calc_busy_i | (cnt_q != '0);
endmodule

// File: rtl/upd_channel.sv
module upd_channel
  import upd_ctrl_pkg::*;
#(
  parameter int          DW       = 14,
  parameter logic [DW-1:0] GND_CODE = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          we_b_i,
  input  logic [DW-1:0] data_i,
  input  logic          ab_we_i,
  input  logic          ab_bit_i,
  input  logic          fire_i,
  input  logic          clr_ni,
  output logic [DW-1:0] out_o,
  output logic          upd_o
);
  logic [DW-1:0] hold_a_q, hold_b_q, dac_q;
  src_e          src_q;
  logic          dirty_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_a_q <= '0;
      hold_b_q <= '0;
      dac_q    <= '0;
      src_q    <= SRC_A;
      dirty_q  <= 1'b0;
      upd_q    <= 1'b0;
    end else begin
      if (we_i && we_b_i)  hold_b_q <= data_i;
      if (we_i && !we_b_i) hold_a_q <= data_i;
      if (ab_we_i) src_q <= ab_bit_i ? SRC_B : SRC_A;
      if (fire_i && dirty_q) dac_q <= (src_q == SRC_B) ? hold_b_q : hold_a_q;
      // write on a commit edge stays pending for the next commit
      dirty_q <= (dirty_q & ~fire_i) | we_i;
      upd_q   <= fire_i & dirty_q;
    end
  end

  assign out_o = clr_ni ? dac_q : GND_CODE;
  assign upd_o = upd_q;
endmodule

// File: rtl/upd_ctrl.sv
module upd_ctrl
  import upd_ctrl_pkg::*;
#(
  parameter int            N_CH     = 40,
  parameter int            DW       = 14,
  parameter int            AB_HOLD  = 100,
  parameter logic [DW-1:0] GND_CODE = '0,
  localparam int           CW       = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             clr_ni,
  input  logic             busy_ni,
  output logic             busy_pull_o,
  input  logic             calc_busy_i,
  input  logic             ab_we_i,
  input  logic [N_CH-1:0]  ab_sel_i,
  input  logic             hold_we_i,
  input  logic             hold_b_i,
  input  logic [CW-1:0]    hold_ch_i,
  input  logic [DW-1:0]    hold_data_i,
  output logic [N_CH*DW-1:0] out_o,
  output logic [N_CH-1:0]  upd_o
);
  logic fire;

  upd_trigger u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_ni(load_ni),
    .clr_ni (clr_ni),
    .busy_ni(busy_ni),
    .fire_o (fire)
  );

  busy_hold #(.AB_HOLD(AB_HOLD)) u_busy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ab_we_i    (ab_we_i),
    .calc_busy_i(calc_busy_i),
    .pull_o     (busy_pull_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic we_ch;
    assign we_ch = hold_we_i && (hold_ch_i == CW'(g));
    upd_channel #(.DW(DW), .GND_CODE(GND_CODE)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_ch),
      .we_b_i  (hold_b_i),
      .data_i  (hold_data_i),
      .ab_we_i (ab_we_i),
      .ab_bit_i(ab_sel_i[g]),
      .fire_i  (fire),
      .clr_ni  (clr_ni),
      .out_o   (out_o[g*DW +: DW]),
      .upd_o   (upd_o[g])
    );
  end
endmodule

// File: rtl/upd_ctrl_chk.sv
module upd_ctrl_chk #(
  parameter int            N_CH     = 40,
  parameter int            DW       = 14,
  parameter int            AB_HOLD  = 100,
  parameter logic [DW-1:0] GND_CODE = '0,
  localparam int           CW       = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_ni,
  input logic               busy_ni,
  input logic               busy_pull_o,
  input logic               ab_we_i,
  input logic               hold_we_i,
  input logic [CW-1:0]      hold_ch_i,
  input logic [N_CH*DW-1:0] out_o,
  input logic [N_CH-1:0]    upd_o
);
  logic [N_CH-1:0] wr_dec, wr_q, seen_q;

  always_comb begin
    wr_dec = '0;
    if (hold_we_i) wr_dec[hold_ch_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      seen_q <= '0;
    end else begin
      wr_q   <= wr_dec;
      seen_q <= (seen_q & ~upd_o) | wr_q;
    end
  end

  a_r3_upd_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o & ~seen_q) == '0);

  a_r5_no_upd_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_ni |=> upd_o == '0);

  a_r7_ab_write_pulls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_we_i |=> busy_pull_o);

  a_r8_no_upd_in_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> upd_o == '0);

  a_r9_out_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && $past(clr_ni) && upd_o == '0) |-> $stable(out_o));
endmodule

bind upd_ctrl upd_ctrl_chk #(
  .N_CH(N_CH), .DW(DW), .AB_HOLD(AB_HOLD), .GND_CODE(GND_CODE)
) u_chk (.*);

// File: tb/upd_ctrl_bench.sv
`timescale 1ns/1ps
module upd_ctrl_bench;
  localparam int N_CH = 4;
  localparam int DW = 8;
  localparam int AB_HOLD = 6;
  localparam logic [DW-1:0] GND = 8'h80;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_n = 1'b1, clr_n = 1'b1, ext_hold = 1'b0, calc = 1'b0;
  logic ab_we = 1'b0, hold_we = 1'b0, hold_b = 1'b0;
  logic [N_CH-1:0] ab_sel = '0;
  logic [CW-1:0] hold_ch = '0;
  logic [DW-1:0] hold_data = '0;
  logic busy_pull, line_n;
  logic [N_CH*DW-1:0] out;
  logic [N_CH-1:0] upd;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;
  assign line_n = ~(busy_pull | ext_hold);

  upd_ctrl #(.N_CH(N_CH), .DW(DW), .AB_HOLD(AB_HOLD), .GND_CODE(GND)) u_upd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .clr_ni(clr_n),
    .busy_ni(line_n), .busy_pull_o(busy_pull), .calc_busy_i(calc),
    .ab_we_i(ab_we), .ab_sel_i(ab_sel), .hold_we_i(hold_we), .hold_b_i(hold_b),
    .hold_ch_i(hold_ch), .hold_data_i(hold_data), .out_o(out), .upd_o(upd)
  );

  // behavioural reference
  int m_ha[N_CH], m_hb[N_CH], m_dac[N_CH], m_sel[N_CH], m_dirty[N_CH], m_upd[N_CH];
  int m_cnt;
  bit m_load_q, m_line_q, m_pend;

  always @(posedge clk) begin
    bit line, fall, rise, fire;
    if (!rst_n) begin
      for (int c = 0; c < N_CH; c++) begin
        m_ha[c] = 0; m_hb[c] = 0; m_dac[c] = 0; m_sel[c] = 0; m_dirty[c] = 0; m_upd[c] = 0;
      end
      m_cnt = 0; m_load_q = 1; m_line_q = 1; m_pend = 0;
    end else begin
      line = !(calc || m_cnt > 0 || ext_hold);
      fall = m_load_q && !load_n;
      rise = !m_line_q && line;
      fire = clr_n && line && (m_pend || fall || (!load_n && rise));
      for (int c = 0; c < N_CH; c++) begin
        m_upd[c] = (fire && m_dirty[c]) ? 1 : 0;
        if (m_upd[c] != 0) m_dac[c] = (m_sel[c] != 0) ? m_hb[c] : m_ha[c];
        if (fire) m_dirty[c] = 0;
        if (hold_we && hold_ch == c) begin
          if (hold_b) m_hb[c] = hold_data; else m_ha[c] = hold_data;
          m_dirty[c] = 1;
        end
        if (ab_we) m_sel[c] = ab_sel[c];
      end
      if (!clr_n || fire) m_pend = 0;
      else if (fall) m_pend = 1;
      if (ab_we) m_cnt = AB_HOLD;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_load_q = load_n;
      m_line_q = line;
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle compare, away from both edges
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      for (int c = 0; c < N_CH; c++) begin
        check("R2 R8 out lane vs model", out[c*DW +: DW], clr_n ? m_dac[c] : GND);
        check("R3 upd bit vs model", upd[c], m_upd[c]);
      end
      check("R7 pull vs model", busy_pull, (calc || m_cnt > 0) ? 1 : 0);
    end
  end

  function automatic int lane(int c);
    return out[c*DW +: DW];
  endfunction

  task automatic ne(); @(negedge clk); endtask
  task automatic pe(); @(posedge clk); #1; endtask

  task automatic wr(int ch, bit b, int d);
    ne(); hold_we = 1; hold_ch = CW'(ch); hold_b = b; hold_data = DW'(d);
    ne(); hold_we = 0;
  endtask

  task automatic load_pulse(int exp_upd, string tag);
    ne(); load_n = 0; pe();
    check(tag, upd, exp_upd);
    ne(); load_n = 1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    pe();
    // R1
    for (int c = 0; c < N_CH; c++) check("R1 reset lane", lane(c), 0);
    check("R1 reset upd", upd, 0);
    check("R1 reset pull", busy_pull, 0);

    // R2 R3 R4: ch2 written on B but sourced from A
    wr(0, 0, 'h11); wr(1, 0, 'h22); wr(2, 1, 'h33);
    load_pulse('b0111, "R2 commit upd");
    check("R2 ch0", lane(0), 'h11);
    check("R4 ch2 from A", lane(2), 0);
    check("R3 ch3 untouched", lane(3), 0);
    load_pulse(0, "R3 no write no upd");

    // R7 and R4 source B
    ne(); ab_we = 1; ab_sel = 4'b0100;
    ne(); ab_we = 0;
    for (int k = 1; k < AB_HOLD; k++) begin pe(); check("R7 hold window", busy_pull, 1); end
    pe(); check("R7 hold ended", busy_pull, 0);
    wr(2, 1, 'h44);
    load_pulse('b0100, "R4 commit ch2");
    check("R4 ch2 from B", lane(2), 'h44);

    // R5: another device holds the line
    wr(3, 0, 'h55);
    ne(); ext_hold = 1;
    ne(); load_n = 0; pe(); check("R5 held off", upd, 0);
    ne(); load_n = 1; pe(); check("R5 still held", upd, 0);
    ne(); ext_hold = 0; pe(); check("R5 latched commit", upd, 'b1000);
    check("R5 ch3", lane(3), 'h55);

    // R6: load held low, commit on release
    ne(); load_n = 0;
    ne(); hold_we = 1; hold_ch = 0; hold_b = 0; hold_data = 'h66; calc = 1;
    ne(); hold_we = 0; pe(); check("R6 busy no upd", upd, 0);
    ne(); calc = 0; pe(); check("R6 release commit", upd, 'b0001);
    check("R6 ch0", lane(0), 'h66);
    ne(); load_n = 1;

    // R8 R9 clear
    ne(); clr_n = 0; pe();
    for (int c = 0; c < N_CH; c++) check("R8 ground lane", lane(c), GND);
    wr(1, 0, 'h77);
    load_pulse(0, "R8 load ignored");
    ne(); clr_n = 1; pe();
    check("R9 ch0 back", lane(0), 'h66);
    check("R9 ch1 old value", lane(1), 'h22);
    check("R9 ch2 back", lane(2), 'h44);
    load_pulse('b0010, "R9 write kept");
    check("R9 ch1 new", lane(1), 'h77);

    // R8 pending dropped by clear
    wr(3, 0, 'h5A);
    ne(); calc = 1;
    ne(); load_n = 0;
    ne(); load_n = 1; clr_n = 0;
    ne(); clr_n = 1;
    ne(); calc = 0; pe(); check("R8 pending dropped", upd, 0);
    check("R8 ch3 unchanged", lane(3), 'h55);
    load_pulse('b1000, "R8 later commit");
    check("R8 ch3 new", lane(3), 'h5A);

    // R10 write on commit edge
    wr(0, 0, 'h90);
    ne(); hold_we = 1; hold_ch = 0; hold_b = 0; hold_data = 'h99; load_n = 0;
    pe(); check("R10 commit upd", upd, 'b0001);
    check("R10 older value", lane(0), 'h90);
    ne(); hold_we = 0; load_n = 1;
    load_pulse('b0001, "R10 still marked");
    check("R10 newer value", lane(0), 'h99);

    repeat (3) pe();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule